// File: doc/BRIEF.md
# Four-Channel Pulse Width Modulator with Period-Aligned Updates

This block generates four independent pulse-width-modulated outputs, each with its own prescaled time base, period, duty threshold and output polarity. Software reaches it over a small register bus with 32-bit data, byte addresses and single-cycle read and write strobes. A global pair of set-only registers starts and stops channels, a status register shows which channels are running, and an interrupt-status register collects one period-end flag per channel. Reading that register clears it.

A running channel cannot take direct duty or period writes. Each channel instead has one shared staging register whose target, duty or period, is picked by a mode bit. A value written there is held and copied into the chosen register on the clock edge where the counter wraps, so a period is never cut short or stretched by a reload in mid-flight. Stopping is also aligned to the wrap: a stop request lets the current period finish, and the status bit stays high until then.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: After reset every channel is stopped, every register reads 0, `pwm_out` is 4'b0000, `irq` is 0 and `rd_data` is 0.
- R2: Writing to 0x004 starts each channel whose bit (bit c for channel c, c = 0..3) is 1. Writing to 0x008 requests a stop for each running channel whose bit is 1. Bits written as 0 have no effect. Reading 0x00C returns the running flags in bits 3:0.
- R3: The channel mode register is at 0x200 + 0x20*c. Its bits 3:0 hold a prescale select p. A running channel's counter advances once every 2^p clock cycles for p = 0..10. For p = 11..15 the counter and prescaler hold still.
- R4: The counter counts 0, 1, ..., P, where P is the period register at 0x208 + 0x20*c, and then returns to 0. The tick that takes it from P to 0 is the period end, so one period lasts P+1 ticks.
- R5: The channel is active while it is running and its counter value n satisfies D <= n < P, where D is the duty register at 0x204 + 0x20*c. Each `pwm_out` bit equals the active flag XOR mode bit 9. A stopped channel therefore outputs the value of mode bit 9.
- R6: Writes to the duty or period register take effect at once while the channel is stopped. While it runs they are ignored, and the register reads back its old value.
- R7: A write to the staging register at 0x210 + 0x20*c on a running channel is held. At the next period end it is copied into the duty register if mode bit 10 is 0, or into the period register if mode bit 10 is 1. On a stopped channel it is copied at once.
- R8: Only bits 15:0 of the duty, period and staging registers are kept. The mode register keeps only bits 3:0, 9 and 10. Every other bit reads 0.
- R9: Bit c of the interrupt-status register at 0x01C is set at every period end of channel c. A read returns the flags and clears them all, except that a period end in the same cycle as the read stays set. `irq` is 1 whenever any flag is set.
- R10: A stop request takes effect at the channel's next period end. Until then the running flag stays 1 and the output keeps modulating.
- R11: Reads of unmapped addresses return 0, writes to them change nothing, and reads of 0x004 and 0x008 return 0.
- R12: `rd_data` is loaded on the clock edge that samples `rd_en`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pwm_out | output | 4 | One modulated output per channel |
| irq | output | 1 | OR of the interrupt-status flags |

## Verification
On every cycle the assertions check four things: a running counter never passes its period, a stopped channel sits at its polarity level, a channel stops or starts only at a period end or an enable write, and a held update never survives a period end it was not renewed in. The interrupt-status clear-on-read rule is checked the same way. What only the bench scenarios can show is the arithmetic in the waveform: the active-cycle count per period under several prescale settings, the register that receives a held update for each target bit, the frozen counter under a reserved prescale code, and the unmapped-address map. A behavioural model checks these every clock alongside the directed reads.

// File: rtl/pwm_quad_pkg.sv
// Shared address map, field positions and decode types for the
// four-channel PWM. Assumes a 12-bit byte address space and that the
// channel window base is aligned to the size of the whole window.
package pwm_quad_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_START  = 12'h004;
    localparam logic [ADDR_W-1:0] A_STOP   = 12'h008;
    localparam logic [ADDR_W-1:0] A_RUNNING = 12'h00C;
    localparam logic [ADDR_W-1:0] A_EVENTS = 12'h01C;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 12'h200;

    localparam int CH_STRIDE_LOG2 = 5;

    localparam logic [CH_STRIDE_LOG2-1:0] O_MODE  = 5'h00;
    localparam logic [CH_STRIDE_LOG2-1:0] O_DUTY  = 5'h04;
    localparam logic [CH_STRIDE_LOG2-1:0] O_PER   = 5'h08;
    localparam logic [CH_STRIDE_LOG2-1:0] O_STAGE = 5'h10;

    localparam int MB_POL = 9;
    localparam int MB_TGT = 10;

    typedef enum logic [2:0] {
        G_NONE, G_START, G_STOP, G_RUNNING, G_EVENTS
    } glob_reg_e;

    typedef enum logic [2:0] {
        C_NONE, C_MODE, C_DUTY, C_PER, C_STAGE
    } chan_reg_e;

endpackage

// File: rtl/pwm_addr_decode.sv
// Address decoder: classifies a byte address as a global register, a
// channel register (with channel index) or unmapped. Purely
// combinational. Assumes A_CH_BASE is aligned to NUM_CH << stride so
// the channel index is a plain bit slice of the address.
module pwm_addr_decode
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CH_IDX_W = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output glob_reg_e           glob_sel,
    output logic                ch_hit,
    output logic [CH_IDX_W-1:0] ch_idx,
    output chan_reg_e           ch_sel
);

    localparam logic [ADDR_W:0] CH_END =
        (ADDR_W+1)'(A_CH_BASE) + (ADDR_W+1)'(NUM_CH << CH_STRIDE_LOG2);

    logic in_window;

    // Global register match.
    always_comb begin
        case (addr)
            A_START:   glob_sel = G_START;
            A_STOP:    glob_sel = G_STOP;
            A_RUNNING: glob_sel = G_RUNNING;
            A_EVENTS:  glob_sel = G_EVENTS;
            default:   glob_sel = G_NONE;
        endcase
    end

    assign in_window = (addr >= A_CH_BASE) && ({1'b0, addr} < CH_END);
    assign ch_idx    = addr[CH_STRIDE_LOG2 +: CH_IDX_W];

    // Channel register match inside the window.
    always_comb begin
        ch_sel = C_NONE;
        if (in_window) begin
            case (addr[CH_STRIDE_LOG2-1:0])
                O_MODE:  ch_sel = C_MODE;
                O_DUTY:  ch_sel = C_DUTY;
                O_PER:   ch_sel = C_PER;
                O_STAGE: ch_sel = C_STAGE;
                default: ch_sel = C_NONE;
            endcase
        end
    end

    assign ch_hit = (ch_sel != C_NONE);

endmodule

// File: rtl/pwm_channel.sv
// One PWM channel: prescaler, wrap counter, duty/period registers, a
// staging register applied at the wrap, and a deferred stop. Assumes
// PRE_MAX >= 1 and that at most one write strobe is active per cycle.
module pwm_channel
    import pwm_quad_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRE_SEL_W = 4,
    parameter int PRE_MAX   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_set,
    input  logic                 stop_set,
    input  logic                 mode_wr,
    input  logic                 duty_wr,
    input  logic                 per_wr,
    input  logic                 stage_wr,
    input  logic [CNT_W-1:0]     wr_val,
    input  logic [PRE_SEL_W-1:0] wr_pre,
    input  logic                 wr_pol,
    input  logic                 wr_tgt,
    output logic                 running,
    output logic                 period_end,
    output logic                 pwm_o,
    output logic [DATA_W-1:0]    mode_rd,
    output logic [CNT_W-1:0]     duty_rd,
    output logic [CNT_W-1:0]     per_rd,
    output logic [CNT_W-1:0]     stage_rd
);

    localparam int PRE_CNT_W = PRE_MAX;
    localparam logic [PRE_SEL_W-1:0] PRE_MAX_V = PRE_SEL_W'(PRE_MAX);

    logic [PRE_SEL_W-1:0] pre_sel_q;
    logic                 pol_q, tgt_q;
    logic [CNT_W-1:0]     duty_q, per_q, stage_q, cnt_q;
    logic                 pend_q, run_q, stop_q;
    logic [PRE_CNT_W-1:0] pre_cnt_q, pre_lim;
    logic                 pre_ok, tick, wrap, active;

    assign pre_ok  = (pre_sel_q <= PRE_MAX_V);
    assign pre_lim = pre_ok ? ({PRE_CNT_W{1'b1}} >> (PRE_MAX_V - pre_sel_q)) : '0;
    assign tick    = run_q && pre_ok && (pre_cnt_q >= pre_lim);
    assign wrap    = tick && (cnt_q == per_q);
    assign active  = run_q && (cnt_q >= duty_q) && (cnt_q < per_q);

    // Time base: prescaler, counter, run flag and deferred stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            stop_q    <= 1'b0;
            cnt_q     <= '0;
            pre_cnt_q <= '0;
        end else begin
            if (run_q && pre_ok)
                pre_cnt_q <= tick ? '0 : pre_cnt_q + 1'b1;
            if (tick)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap && stop_q) begin
                run_q  <= 1'b0;
                stop_q <= 1'b0;
            end
            if (stop_set && run_q)
                stop_q <= 1'b1;
            if (start_set) begin
                run_q  <= 1'b1;
                stop_q <= 1'b0;
                if (!run_q) begin
                    cnt_q     <= '0;
                    pre_cnt_q <= '0;
                end
            end
        end
    end

    // Duty, period and staging registers with wrap-aligned reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q  <= '0;
            per_q   <= '0;
            stage_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (wrap && pend_q) begin
                if (tgt_q) per_q  <= stage_q;
                else       duty_q <= stage_q;
                pend_q <= 1'b0;
            end
            if (duty_wr && !run_q) duty_q <= wr_val;
            if (per_wr && !run_q)  per_q  <= wr_val;
            if (stage_wr) begin
                stage_q <= wr_val;
                if (run_q)      pend_q <= 1'b1;
                else if (tgt_q) per_q  <= wr_val;
                else            duty_q <= wr_val;
            end
        end
    end

    // Mode register: prescale select, polarity, staging target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_sel_q <= '0;
            pol_q     <= 1'b0;
            tgt_q     <= 1'b0;
        end else if (mode_wr) begin
            pre_sel_q <= wr_pre;
            pol_q     <= wr_pol;
            tgt_q     <= wr_tgt;
        end
    end

    // Mode read-back with unused bits at zero.
    always_comb begin
        mode_rd                  = '0;
        mode_rd[PRE_SEL_W-1:0]   = pre_sel_q;
        mode_rd[MB_POL]          = pol_q;
        mode_rd[MB_TGT]          = tgt_q;
    end

    assign running    = run_q;
    assign period_end = wrap;
    assign pwm_o      = active ^ pol_q;
    assign duty_rd    = duty_q;
    assign per_rd     = per_q;
    assign stage_rd   = stage_q;

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= per_q));

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pwm_o == pol_q));

    // R10
    stop_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(wrap));

    // R2
    start_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(start_set));

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !stage_wr) |=> !pend_q);

endmodule

// File: rtl/pwm_quad_ctrl.sv
// Top level: register bus, global start/stop/status, clear-on-read
// event flags and NUM_CH channel instances. Read data is registered and
// held between reads. Assumes wr_en and rd_en are single-cycle strobes.
module pwm_quad_ctrl
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int CNT_W     = 16,
    parameter int PRE_SEL_W = 4,
    parameter int PRE_MAX   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              irq
);

    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    glob_reg_e            glob_sel;
    chan_reg_e            ch_sel;
    logic                 ch_hit;
    logic [CH_IDX_W-1:0]  ch_idx;
    logic [NUM_CH-1:0]    run_vec, wrap_vec, isr_q;
    logic [DATA_W-1:0]    rd_mux, rd_q;
    logic                 evt_rd;
    logic                 unused_wr_hi;

    logic [DATA_W-1:0] mode_rd  [NUM_CH];
    logic [CNT_W-1:0]  duty_rd  [NUM_CH];
    logic [CNT_W-1:0]  per_rd   [NUM_CH];
    logic [CNT_W-1:0]  stage_rd [NUM_CH];

    assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

    pwm_addr_decode #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_dec (
        .addr     (addr),
        .glob_sel (glob_sel),
        .ch_hit   (ch_hit),
        .ch_idx   (ch_idx),
        .ch_sel   (ch_sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_c;
        assign sel_c = wr_en && ch_hit && (ch_idx == CH_IDX_W'(c));

        pwm_channel #(.CNT_W(CNT_W), .PRE_SEL_W(PRE_SEL_W), .PRE_MAX(PRE_MAX)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_set  (wr_en && (glob_sel == G_START) && wr_data[c]),
            .stop_set   (wr_en && (glob_sel == G_STOP) && wr_data[c]),
            .mode_wr    (sel_c && (ch_sel == C_MODE)),
            .duty_wr    (sel_c && (ch_sel == C_DUTY)),
            .per_wr     (sel_c && (ch_sel == C_PER)),
            .stage_wr   (sel_c && (ch_sel == C_STAGE)),
            .wr_val     (wr_data[CNT_W-1:0]),
            .wr_pre     (wr_data[PRE_SEL_W-1:0]),
            .wr_pol     (wr_data[MB_POL]),
            .wr_tgt     (wr_data[MB_TGT]),
            .running    (run_vec[c]),
            .period_end (wrap_vec[c]),
            .pwm_o      (pwm_out[c]),
            .mode_rd    (mode_rd[c]),
            .duty_rd    (duty_rd[c]),
            .per_rd     (per_rd[c]),
            .stage_rd   (stage_rd[c])
        );
    end

    assign evt_rd = rd_en && (glob_sel == G_EVENTS);

    // Read multiplexer over global and channel registers.
    always_comb begin
        rd_mux = '0;
        case (glob_sel)
            G_RUNNING: rd_mux = DATA_W'(run_vec);
            G_EVENTS:  rd_mux = DATA_W'(isr_q);
            default:   rd_mux = '0;
        endcase
        if (ch_hit) begin
            case (ch_sel)
                C_MODE:  rd_mux = mode_rd[ch_idx];
                C_DUTY:  rd_mux = DATA_W'(duty_rd[ch_idx]);
                C_PER:   rd_mux = DATA_W'(per_rd[ch_idx]);
                C_STAGE: rd_mux = DATA_W'(stage_rd[ch_idx]);
                default: rd_mux = '0;
            endcase
        end
    end

    // Event flags: set on period end, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (evt_rd ? '0 : isr_q) | wrap_vec;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
    end

    assign rd_data = rd_q;
    assign irq     = |isr_q;

    // R9
    isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (isr_q == $past(wrap_vec)));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/test_pwm_quad_ctrl.sv
`timescale 1ns/1ps
module test_pwm_quad_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  pwm_out;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    pwm_quad_ctrl i_pwm_quad_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_run[4], m_stop[4], m_cnt[4], m_pre[4], m_mode[4];
    int m_duty[4], m_per[4], m_stage[4], m_pend[4];
    int m_isr, m_rd;

    function automatic int m_read(int a);
        int c;
        if (a == 'h00C) begin
            int v = 0;
            for (int k = 0; k < 4; k++) if (m_run[k] != 0) v |= (1 << k);
            return v;
        end
        if (a == 'h01C) return m_isr;
        if (a >= 'h200 && a < 'h280) begin
            c = (a - 'h200) >> 5;
            case (a & 'h1F)
                'h00: return m_mode[c];
                'h04: return m_duty[c];
                'h08: return m_per[c];
                'h10: return m_stage[c];
                default: return 0;
            endcase
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_run[c] = 0; m_stop[c] = 0; m_cnt[c] = 0; m_pre[c] = 0;
                m_mode[c] = 0; m_duty[c] = 0; m_per[c] = 0; m_stage[c] = 0; m_pend[c] = 0;
            end
            m_isr = 0; m_rd = 0;
        end else begin
            int nisr;
            int a;
            int d;
            a = int'(addr);
            d = int'(wr_data);
            if (rd_en) m_rd = m_read(a);
            nisr = (rd_en && a == 'h01C) ? 0 : m_isr;
            for (int c = 0; c < 4; c++) begin
                int p;
                int old_run;
                p = m_mode[c] & 15;
                old_run = m_run[c];
                if (m_run[c] != 0 && p <= 10) begin
                    if (m_pre[c] >= (1 << p) - 1) begin
                        m_pre[c] = 0;
                        if (m_cnt[c] == m_per[c]) begin
                            m_cnt[c] = 0;
                            nisr |= (1 << c);
                            if (m_pend[c] != 0) begin
                                if ((m_mode[c] >> 10) & 1) m_per[c] = m_stage[c];
                                else m_duty[c] = m_stage[c];
                                m_pend[c] = 0;
                            end
                            if (m_stop[c] != 0) begin m_run[c] = 0; m_stop[c] = 0; end
                        end else m_cnt[c]++;
                    end else m_pre[c]++;
                end
                if (wr_en) begin
                    if (a == 'h004 && ((d >> c) & 1)) begin
                        if (old_run == 0) begin m_cnt[c] = 0; m_pre[c] = 0; end
                        m_run[c] = 1; m_stop[c] = 0;
                    end
                    if (a == 'h008 && ((d >> c) & 1) && old_run != 0) m_stop[c] = 1;
                    if (a >= 'h200 + c * 'h20 && a < 'h220 + c * 'h20) begin
                        case (a & 'h1F)
                            'h00: m_mode[c] = d & 'h60F;
                            'h04: if (old_run == 0) m_duty[c] = d & 'hFFFF;
                            'h08: if (old_run == 0) m_per[c] = d & 'hFFFF;
                            'h10: begin
                                m_stage[c] = d & 'hFFFF;
                                if (old_run != 0) m_pend[c] = 1;
                                else if ((m_mode[c] >> 10) & 1) m_per[c] = d & 'hFFFF;
                                else m_duty[c] = d & 'hFFFF;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            m_isr = nisr;
        end
    end

    function automatic int m_pwm();
        int v = 0;
        for (int c = 0; c < 4; c++) begin
            int act;
            act = (m_run[c] != 0 && m_cnt[c] >= m_duty[c] && m_cnt[c] < m_per[c]) ? 1 : 0;
            if ((act ^ ((m_mode[c] >> 9) & 1)) != 0) v |= (1 << c);
        end
        return v;
    endfunction

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            checks++;
            if (int'(pwm_out) != m_pwm()) begin
                failures++;
                $display("FAIL R5 pwm_out actual=%h expected=%h t=%0t", pwm_out, m_pwm(), $time);
            end
            checks++;
            if (irq != (m_isr != 0)) begin
                failures++;
                $display("FAIL R9 irq actual=%0d expected=%0d t=%0t", irq, (m_isr != 0), $time);
            end
            checks++;
            if (int'(rd_data) != m_rd) begin
                failures++;
                $display("FAIL R12 rd_data actual=%h expected=%h t=%0t", rd_data, m_rd, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 12'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_en = 1'b1; addr = 12'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_level(input int ch, input int lvl, input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (int'(pwm_out[ch]) == lvl) k++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    // ---------------- scenarios ----------------
    initial begin
        int v;
        int k;
        int tries;
        idle(4);
        rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pwm_out", int'(pwm_out), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        rd('h00C, v); chk("R1 running", v, 0);
        rd('h208, v); chk("R1 period", v, 0);

        // R8: field masking
        wr('h208, 'h0001_0009); rd('h208, v); chk("R8 period low half", v, 9);
        wr('h204, 'hABCD_0003); rd('h204, v); chk("R8 duty low half", v, 3);
        wr('h200, 'hFFFF_F6F0); rd('h200, v); chk("R8 mode fields", v, 'h600);
        chk("R5 stopped polarity level", int'(pwm_out[0]), 1);
        wr('h200, 0);
        chk("R5 stopped normal level", int'(pwm_out[0]), 0);

        // R11: unmapped space
        wr('h20C, 'h55); rd('h20C, v); chk("R11 hole read", v, 0);
        rd('h208, v); chk("R11 hole write ignored", v, 9);
        rd('h100, v); chk("R11 unmapped low", v, 0);
        wr('h290, 5); rd('h290, v); chk("R11 beyond window", v, 0);
        rd('h004, v); chk("R11 start reg reads zero", v, 0);

        // R2/R4/R5: channel 0, period 9 duty 3, prescale 1
        wr('h004, 'h1); rd('h00C, v); chk("R2 start ch0", v, 1);
        wr('h004, 'h0); rd('h00C, v); chk("R2 zero bits ignored", v, 1);
        idle(12);
        count_level(0, 1, 10, k); chk("R4 R5 active count ch0", k, 6);
        rd('h01C, v); chk("R9 flag set ch0", v & 1, 1);
        wr('h204, 7); rd('h204, v); chk("R6 duty write ignored while running", v, 3);
        wr('h208, 4); rd('h208, v); chk("R6 period write ignored while running", v, 9);

        // R7: channel 1, prescale 16, staged duty then period
        wr('h220, 'h004); wr('h228, 7); wr('h224, 2);
        rd('h224, v); chk("R6 direct duty while stopped", v, 2);
        wr('h004, 'h2);
        wr('h230, 5); rd('h224, v); chk("R7 staged duty held", v, 2);
        idle(140); rd('h224, v); chk("R7 staged duty applied", v, 5);
        wr('h220, 'h404); wr('h230, 3); rd('h228, v); chk("R7 staged period held", v, 7);
        idle(140); rd('h228, v); chk("R7 staged period applied", v, 3);
        wr('h250, 4); rd('h244, v); chk("R7 stopped channel staging immediate", v, 4);

        // R10: deferred stop on channel 1, aligned just after a wrap
        tries = 0;
        do begin rd('h01C, v); tries++; end while (((v >> 1) & 1) == 0 && tries < 500);
        wr('h008, 'h2); rd('h00C, v); chk("R10 still running after stop write", (v >> 1) & 1, 1);
        idle(80); rd('h00C, v); chk("R10 stopped at period end", (v >> 1) & 1, 0);
        chk("R10 idle level ch1", int'(pwm_out[1]), 0);
        wr('h008, 'h1); idle(15); rd('h00C, v); chk("R10 ch0 stopped", v & 1, 0);

        // R3: channel 2 prescale 4 with inverted polarity
        wr('h240, 'h202); wr('h248, 3); wr('h244, 1); wr('h004, 'h4);
        idle(20);
        count_level(2, 0, 16, k); chk("R3 R5 prescale 4 inverted", k, 8);
        // R3: channel 3 at the largest prescale
        wr('h260, 10); wr('h268, 1); wr('h264, 0); wr('h004, 'h8);
        idle(10);
        count_level(3, 1, 2048, k); chk("R3 prescale 1024", k, 1024);
        // R3: reserved code freezes the counter
        wr('h260, 11); rd('h01C, v);
        idle(3000); rd('h01C, v); chk("R3 reserved code no period end", (v >> 3) & 1, 0);
        wr('h260, 0); wr('h008, 'hC);
        idle(100); rd('h00C, v); chk("R10 all stopped", v, 0);
        chk("R5 resting levels", int'(pwm_out), 'h4);

        // R9: clear on read
        rd('h01C, v); rd('h01C, v); chk("R9 cleared by read", v, 0);
        chk("R9 irq low", int'(irq), 0);

        // R12: read data held
        rd('h248, v); idle(6); chk("R12 read data held", int'(rd_data), 3);

        idle(4);
        finish_run();
    end

endmodule